// File: doc/BRIEF.md
# Cycle Counter with Tapped Postscaler

The block keeps a 32-bit free-running cycle count. The count advances once per core clock while its enable bit is set and the core is not halted, and it wraps to zero past its top value. One of two counter bits is watched, and every toggle of that bit, rising or falling, is a tap event. A 4-bit reloadable down-counter (the postscaler) divides the tap events. The resulting periodic event goes to a PC-sample request when sampling is enabled. Otherwise it goes to a cycle-event output if that output is enabled.

A second, slower tap on one of three high counter bits gives a one-cycle synchronization pulse. Software reaches the block through two registers: a control word and the counter itself. A write to the counter overrides counting in that cycle. Capture of the program counter and the formatting of trace packets are done by other logic that consumes these outputs.

Top module: `cyc_profiler`

## Requirements
- R1: While the enable (control bit 0) is 1 and `core_halted` is 0, the counter rises by one each clock. It wraps from 0xFFFFFFFF to 0.
- R2: While the enable is 0 or `core_halted` is 1, the counter holds its value, and `pc_sample_req`, `cyc_event` and `sync_pulse` stay low.
- R3: A write with `reg_sel`=1 loads `reg_wdata` into the counter at the next edge. It wins over an increment in the same cycle, and a bit change it causes is not a tap event.
- R4: Tap select (control bit 9) watches counter bit 6 when 0 and bit 10 when 1. An increment that changes the watched bit in either direction is a tap event.
- R5: On a tap event, a nonzero postscaler decrements. A zero postscaler fires an event and reloads from the preset (control bits [4:1]). Preset 0 fires on every tap event, and preset N fires on every (N+1)th.
- R6: With PC-sample enable (control bit 12) set, a fired event drives `pc_sample_req` and `cyc_event` stays low. With bit 12 clear, the event drives `cyc_event` only if cycle-event enable (control bit 13) is set.
- R7: Sync select (control bits [11:10]) picks the sync source: 00 is off, 01 is counter bit 24, 10 is bit 26 and 11 is bit 28. Each change of that bit caused by an increment gives a one-cycle `sync_pulse`.
- R8: After reset, the control word, counter and postscaler are zero and all event outputs are low.
- R9: A control read returns the postscaler in bits [8:5], the preset in [4:1] and the other written fields in place, with all unused bits zero. Writes cannot change bits [8:5].
- R10: Each event output is high for exactly one cycle. That cycle is the one in which the counter first shows the value whose watched bit just changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_halted | input | 1 | Core is halted; counting pauses |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 counter |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| pc_sample_req | output | 1 | Request to capture the program counter |
| cyc_event | output | 1 | Periodic cycle event |
| sync_pulse | output | 1 | Slow synchronization pulse |

## Verification
Two functions can fire in the same cycle. The postscaled tap event and the sync pulse coincide when a carry ripples into bit 24: bits 6 and 24 change on the same increment. The bench preloads the counter just below 0x01000000 with both outputs enabled and expects exactly one cycle event and one sync pulse. A counter write also collides with an increment. In that case the bench expects the written value to appear unchanged, with no event, even though the jump flips bit 6.

// File: rtl/cycprof_pkg.sv
package cycprof_pkg;

    localparam int CNT_W      = 32;
    localparam int PS_W       = 4;
    localparam int SYNC_SEL_W = 2;

    // control word layout; postscaler sits directly above its preset
    localparam int EN_BIT   = 0;
    localparam int PRE_LSB  = EN_BIT + 1;
    localparam int PS_LSB   = PRE_LSB + PS_W;
    localparam int TSEL_BIT = PS_LSB + PS_W;
    localparam int SYNC_LSB = TSEL_BIT + 1;
    localparam int PCS_BIT  = SYNC_LSB + SYNC_SEL_W;
    localparam int CEV_BIT  = PCS_BIT + 1;

    typedef struct packed {
        logic                  cev_en;
        logic                  pcs_en;
        logic [SYNC_SEL_W-1:0] sync_sel;
        logic                  tap_sel;
        logic [PS_W-1:0]       preset;
        logic                  cnt_en;
    } ctrl_t;

endpackage

// File: rtl/cycprof_counter.sv
module cycprof_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_en,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] flip
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;
    logic [W-1:0] plus1;

    always_comb begin
        plus1 = s_q.cnt + ONE;
        s_d   = s_q;
        flip  = '0;
        if (ld_en) begin
            s_d.cnt = ld_val;
        end else if (inc_en) begin
            s_d.cnt = plus1;
            flip    = s_q.cnt ^ plus1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_q = s_q.cnt;
endmodule

// File: rtl/cycprof_postscale.sv
module cycprof_postscale #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tap_evt,
    input  logic [PS_W-1:0] preset,
    input  logic            pcs_en,
    input  logic            cev_en,
    output logic [PS_W-1:0] ps_q,
    output logic            pc_req,
    output logic            cyc_evt
);
    localparam logic [PS_W-1:0] ONE = {{(PS_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            pc;
        logic            cyc;
    } st_t;

    st_t  s_d, s_q;
    logic fire;

    always_comb begin
        s_d     = s_q;
        s_d.pc  = 1'b0;
        s_d.cyc = 1'b0;
        fire    = 1'b0;
        if (tap_evt) begin
            if (s_q.ps == '0) begin
                fire   = 1'b1;
                s_d.ps = preset;
            end else begin
                s_d.ps = s_q.ps - ONE;
            end
        end
        // sampling request outranks the plain cycle event
        if (fire) begin
            s_d.pc  = pcs_en;
            s_d.cyc = cev_en & ~pcs_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ps_q    = s_q.ps;
    assign pc_req  = s_q.pc;
    assign cyc_evt = s_q.cyc;
endmodule

// File: rtl/cycprof_sync.sv
module cycprof_sync #(
    parameter int SEL_W = 2,
    localparam int NTAP = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTAP-1:0]  tap_flip,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    typedef struct packed {
        logic p;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        s_d.p = 1'b0;
        for (int i = 1; i <= NTAP; i++) begin
            if (sel == SEL_W'(i)) s_d.p = tap_flip[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse = s_q.p;
endmodule

// File: rtl/cyc_profiler.sv
module cyc_profiler
    import cycprof_pkg::*;
#(
    parameter int TAP_LO    = 6,
    parameter int TAP_HI    = 10,
    parameter int SYNC_BASE = 24,
    parameter int SYNC_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_halted,
    input  logic             reg_wr_en,
    input  logic             reg_sel,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             pc_sample_req,
    output logic             cyc_event,
    output logic             sync_pulse
);
    localparam int NSYNC = (1 << SYNC_SEL_W) - 1;

    ctrl_t ctrl_d, ctrl_q;

    logic             cnt_wr, ctrl_wr, cnt_inc, tap_evt, cnt_en_w;
    logic [CNT_W-1:0] cnt_q, flip, ctrl_rb;
    logic [PS_W-1:0]  ps_q;
    logic [NSYNC-1:0] sync_flip;
    logic             unused_flip;

    assign cnt_wr   = reg_wr_en &  reg_sel;
    assign ctrl_wr  = reg_wr_en & ~reg_sel;
    assign cnt_en_w = ctrl_q.cnt_en;
    assign cnt_inc  = cnt_en_w & ~core_halted & ~cnt_wr;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d.cnt_en   = reg_wdata[EN_BIT];
            ctrl_d.preset   = reg_wdata[PRE_LSB +: PS_W];
            ctrl_d.tap_sel  = reg_wdata[TSEL_BIT];
            ctrl_d.sync_sel = reg_wdata[SYNC_LSB +: SYNC_SEL_W];
            ctrl_d.pcs_en   = reg_wdata[PCS_BIT];
            ctrl_d.cev_en   = reg_wdata[CEV_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        ctrl_rb                           = '0;
        ctrl_rb[EN_BIT]                   = ctrl_q.cnt_en;
        ctrl_rb[PRE_LSB +: PS_W]          = ctrl_q.preset;
        ctrl_rb[PS_LSB +: PS_W]           = ps_q;
        ctrl_rb[TSEL_BIT]                 = ctrl_q.tap_sel;
        ctrl_rb[SYNC_LSB +: SYNC_SEL_W]   = ctrl_q.sync_sel;
        ctrl_rb[PCS_BIT]                  = ctrl_q.pcs_en;
        ctrl_rb[CEV_BIT]                  = ctrl_q.cev_en;
        reg_rdata = reg_sel ? cnt_q : ctrl_rb;
    end

    cycprof_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_en (cnt_inc),
        .ld_en  (cnt_wr),
        .ld_val (reg_wdata),
        .cnt_q  (cnt_q),
        .flip   (flip)
    );

    assign tap_evt     = ctrl_q.tap_sel ? flip[TAP_HI] : flip[TAP_LO];
    assign unused_flip = ^flip;

    cycprof_postscale #(.PS_W(PS_W)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_evt (tap_evt),
        .preset  (ctrl_q.preset),
        .pcs_en  (ctrl_q.pcs_en),
        .cev_en  (ctrl_q.cev_en),
        .ps_q    (ps_q),
        .pc_req  (pc_sample_req),
        .cyc_evt (cyc_event)
    );

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync_tap
        assign sync_flip[g] = flip[SYNC_BASE + g * SYNC_STEP];
    end

    cycprof_sync #(.SEL_W(SYNC_SEL_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_flip (sync_flip),
        .sel      (ctrl_q.sync_sel),
        .pulse    (sync_pulse)
    );
endmodule

// File: rtl/cycprof_chk.sv
module cycprof_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             core_halted,
    input logic             reg_wr_en,
    input logic             reg_sel,
    input logic [CNT_W-1:0] reg_wdata,
    input logic [CNT_W-1:0] cnt,
    input logic             cnt_en,
    input logic             pc_sample_req,
    input logic             cyc_event,
    input logic             sync_pulse
);
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en && !core_halted && !(reg_wr_en && reg_sel)
        |=> cnt == CNT_W'($past(cnt) + 1'b1));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en || core_halted) && !(reg_wr_en && reg_sel) |=> $stable(cnt));

    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en || core_halted) |=> !pc_sample_req && !cyc_event && !sync_pulse);

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && reg_sel |=> cnt == $past(reg_wdata));

    assert_route_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_sample_req && cyc_event));

    assert_pc_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sample_req |=> !pc_sample_req);

    assert_cyc_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_event |=> !cyc_event);

    assert_sync_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);
endmodule

bind cyc_profiler cycprof_chk #(.CNT_W(cycprof_pkg::CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_halted   (core_halted),
    .reg_wr_en     (reg_wr_en),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .cnt           (cnt_q),
    .cnt_en        (cnt_en_w),
    .pc_sample_req (pc_sample_req),
    .cyc_event     (cyc_event),
    .sync_pulse    (sync_pulse)
);

// File: tb/sim_cyc_profiler.sv
module sim_cyc_profiler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_halted = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pc_sample_req, cyc_event, sync_pulse;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    cyc_profiler u0 (
        .clk (clk), .rst_n (rst_n), .core_halted (core_halted),
        .reg_wr_en (reg_wr_en), .reg_sel (reg_sel), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .pc_sample_req (pc_sample_req),
        .cyc_event (cyc_event), .sync_pulse (sync_pulse)
    );

    typedef struct packed {
        logic [15:0] ctrl;
        logic [31:0] start;
        logic [15:0] ncyc;
        logic [7:0]  n_pc;
        logic [7:0]  n_cyc;
        logic [7:0]  n_sync;
        logic [31:0] fin;
    } vec_t;

    // control: bit0 en, [4:1] preset, 9 tap sel, [11:10] sync sel, 12 pc sample, 13 cycle event
    localparam vec_t VECS [13] = '{
        '{16'h2001, 32'h0000_0000, 16'd640,  8'd0,  8'd10, 8'd0, 32'h0000_0280},
        '{16'h3001, 32'h0000_0000, 16'd640,  8'd10, 8'd0,  8'd0, 32'h0000_0280},
        '{16'h2003, 32'h0000_0000, 16'd640,  8'd0,  8'd5,  8'd0, 32'h0000_0280},
        '{16'h2207, 32'h0000_0000, 16'd8192, 8'd0,  8'd2,  8'd0, 32'h0000_2000},
        '{16'h0001, 32'h0000_0000, 16'd640,  8'd0,  8'd0,  8'd0, 32'h0000_0280},
        '{16'h2000, 32'h0000_0000, 16'd300,  8'd0,  8'd0,  8'd0, 32'h0000_0000},
        '{16'h2401, 32'h00FF_FFF0, 16'd32,   8'd0,  8'd1,  8'd1, 32'h0100_0010},
        '{16'h0801, 32'h03FF_FFF8, 16'd16,   8'd0,  8'd0,  8'd1, 32'h0400_0008},
        '{16'h0C01, 32'h0FFF_FFF8, 16'd16,   8'd0,  8'd0,  8'd1, 32'h1000_0008},
        '{16'h0001, 32'h00FF_FFF8, 16'd16,   8'd0,  8'd0,  8'd0, 32'h0100_0008},
        '{16'h2001, 32'hFFFF_FFFC, 16'd8,    8'd0,  8'd1,  8'd0, 32'h0000_0004},
        '{16'h0401, 32'h01FF_FFF8, 16'd16,   8'd0,  8'd0,  8'd1, 32'h0200_0008},
        '{16'h3201, 32'h0000_0000, 16'd4096, 8'd4,  8'd0,  8'd0, 32'h0000_1000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; core_halted = 1'b0; reg_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int npc, ncy, nsy;

        // R8: reset state
        do_reset();
        rd(1'b0, v); chk("R8 control", v, 32'h0);
        rd(1'b1, v); chk("R8 counter", v, 32'h0);
        chk("R8 outputs", {29'h0, pc_sample_req, cyc_event, sync_pulse}, 32'h0);

        // R9: postscaler field not writable, unused bits read zero; R2 counter held with enable 0
        wr(1'b0, 32'hFFFF_FFFE);
        rd(1'b0, v); chk("R9 readback", v, 32'h0000_3E1E);
        repeat (5) @(negedge clk);
        rd(1'b1, v); chk("R2 disabled hold", v, 32'h0);

        // vector table: R1 R4 R5 R6 R7
        foreach (VECS[i]) begin
            do_reset();
            wr(1'b1, VECS[i].start);
            wr(1'b0, {16'h0, VECS[i].ctrl});
            npc = 0; ncy = 0; nsy = 0;
            for (int c = 0; c < int'(VECS[i].ncyc); c++) begin
                @(negedge clk);
                if (pc_sample_req) npc++;
                if (cyc_event) ncy++;
                if (sync_pulse) nsy++;
            end
            chk("R5 R6 pc requests", npc, VECS[i].n_pc);
            chk("R5 R6 cycle events", ncy, VECS[i].n_cyc);
            chk("R7 sync pulses", nsy, VECS[i].n_sync);
            rd(1'b1, v); chk("R1 final count", v, VECS[i].fin);
        end

        // R2 halt: counter holds, no events; R10 event timing on release
        do_reset();
        wr(1'b1, 32'h3F);
        core_halted = 1'b1;
        wr(1'b0, 32'h2001);
        ncy = 0;
        repeat (20) begin @(negedge clk); if (cyc_event) ncy++; end
        chk("R2 halted events", ncy, 0);
        rd(1'b1, v); chk("R2 halted hold", v, 32'h3F);
        core_halted = 1'b0;
        @(negedge clk);
        rd(1'b1, v); chk("R1 resume", v, 32'h40);
        chk("R10 event in same cycle", cyc_event, 1'b1);
        @(negedge clk);
        chk("R10 one cycle only", cyc_event, 1'b0);

        // R3 write beats increment and its bit change is no tap event; R4 falling edge
        do_reset();
        wr(1'b0, 32'h2001);
        wr(1'b1, 32'h40);
        rd(1'b1, v); chk("R3 loaded value", v, 32'h40);
        chk("R3 no event from write", cyc_event, 1'b0);
        repeat (63) @(negedge clk);
        rd(1'b1, v); chk("R3 counting resumes", v, 32'h7F);
        chk("R4 before fall", cyc_event, 1'b0);
        @(negedge clk);
        chk("R4 falling tap event", cyc_event, 1'b1);

        // R9 postscaler readback with preset 5; R5 decrement suppresses the event
        do_reset();
        wr(1'b0, 32'h200B);
        repeat (64) @(negedge clk);
        chk("R5 first tap fires", cyc_event, 1'b1);
        rd(1'b0, v); chk("R9 reloaded postscaler", v, 32'h20AB);
        repeat (64) @(negedge clk);
        chk("R5 decrement no event", cyc_event, 1'b0);
        rd(1'b0, v); chk("R9 decremented postscaler", v, 32'h208B);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule